// File: doc/BRIEF.md
# Dual-Channel Modem Control and Status Unit

This block sits beside the serial engines of a two-channel UART. It keeps the modem-side control and status state for each channel. A CPU reaches it over a 68-style bus, meaning one read/write strobe qualified by an active-low chip select, plus a channel-select bit and a 3-bit register address. Each channel has three registers:

- a control register that drives the active-low terminal-ready, request-to-send and user output pins and holds the loopback switch;
- an interrupt-enable register;
- a status register that reports the synchronized modem inputs and latches the release edge of the ring indicator.

A single merged request line tells the CPU that some channel needs service.

The bus is a plain single-cycle strobe, not a stream. A write is taken on every clock edge at which `cs_n` is low and `rw` is low. A read is served combinationally while `cs_n` is low and `rw` is high. There is no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented.

The serial data path passes through the block unchanged, except in local loopback. In loopback the receive output takes the channel's own transmit data, and the transmit pin idles high. The request line is open-drain style: the block only ever asks for the line to be pulled low, and never drives it high.

Top module: `mdm_ctl_dual`

## Requirements
- R1: A write takes `data_in` into the addressed register of the selected channel at the clock edge where `cs_n`=0 and `rw`=0. `data_oe` is 1 exactly while `cs_n`=0 and `rw`=1, and `data_out` is 0 otherwise. A read of address 4 returns control bits [4:0]; a read of address 1 returns enable bits [3:0]; all other bits of these reads are 0.
- R2: Control bit 0 set to 1 drives that channel's `dtr_n` low, and set to 0 drives it high, from the cycle after the write.
- R3: Control bit 1 set to 1 drives that channel's `rts_n` low, and set to 0 drives it high.
- R4: Control bit 3 set to 1 drives that channel's `op2_n` low, and set to 0 drives it high.
- R5: While `rst_n` is low, all registers clear. `dtr_n`, `rts_n` and `op2_n` are high, `irq_pull_low` is 0, and register reads return 0.
- R6: Status register (address 6) bit 5 reads 1 while `dsr_n` is low, and bit 6 reads 1 while `ri_n` is low. Both inputs are taken through a two-stage synchronizer. The other bits, apart from bit 2, read 0.
- R7: A 0-to-1 transition on a channel's `ri_n` sets status bit 2 of that channel. A read of the status register clears the bit, but an edge arriving in the same cycle as the clearing read keeps it set.
- R8: A channel's interrupt is pending when status bit 2 and enable bit 3 (address 1) are both 1. `irq_pull_low` is the OR of the pending interrupts of all channels.
- R9: A read of address 2 returns bit 0 = 0 while that channel's interrupt is pending and 1 otherwise. Bits 7:1 read 0.
- R10: With control bit 4 set, `rx_out` equals that channel's `tx_in`, `rx_pin` is ignored and `tx_pin` is 1. With control bit 4 clear, `rx_out` = `rx_pin` and `tx_pin` = `tx_in`.
- R11: While `rst_n` is low, `rx_out` is 1 whatever `rx_pin` holds.
- R12: An access with `chan_sel`=c touches only channel c. The other channel's outputs and registers are unchanged.
- R13: Addresses 0, 3, 5 and 7 read 0. Writes to them, and writes to address 6, change nothing that can be observed.
- R14: The levels of `dsr_n` and `ri_n` never change `dtr_n`, `rts_n`, `op2_n`, `tx_pin` or `rx_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| chan_sel | input | 1 | Channel select (0 = A, 1 = B) |
| addr | input | 3 | Register address |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Bus drive enable; when 0 the bus is released |
| dsr_n | input | 2 | Active-low data-set-ready, one per channel |
| ri_n | input | 2 | Active-low ring indicator, one per channel |
| dtr_n | output | 2 | Active-low terminal-ready, one per channel |
| rts_n | output | 2 | Active-low request-to-send, one per channel |
| op2_n | output | 2 | Active-low user output, one per channel |
| tx_in | input | 2 | Transmit data from the shift engine |
| tx_pin | output | 2 | Transmit data to the pin |
| rx_pin | input | 2 | Receive data from the pin |
| rx_out | output | 2 | Receive data to the shift engine |
| irq_pull_low | output | 1 | 1 = pull the shared request line low |

## Verification
A corrupted control bit shows on the matching modem pin, or on the loopback steering, in the cycle after the write that should have set it, and on the next readback of address 4. A lost or stuck ring-edge flag shows at `irq_pull_low` and at bit 0 of address 2 within a few cycles of the input edge, and again when the status register is read and then read a second time. A wrong synchronizer reset value would raise a false edge flag right after reset, where the bench expects a clean status register.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_IER = 3'd1;
  localparam logic [ADDR_W-1:0] A_ISR = 3'd2;
  localparam logic [ADDR_W-1:0] A_MCR = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSR = 3'd6;

  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OP2  = 3;
  localparam int CB_LOOP = 4;
  localparam int CTRL_W  = 5;

  localparam int EB_MS   = 3;
  localparam int EN_W    = 4;

  localparam int SB_RIE  = 2;
  localparam int SB_DSR  = 5;
  localparam int SB_RI   = 6;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= {W{RST_VAL}};
    else        st_q[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[s] <= {W{RST_VAL}};
        else        st_q[s] <= st_q[s-1];
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/mdm_chan.sv
module mdm_chan
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ri_n_s,
  input  logic              dsr_n_s,
  input  logic              tx_in,
  output logic              tx_pin,
  input  logic              rx_pin,
  output logic              rx_out,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              op2_n,
  output logic              irq
);
  logic [CTRL_W-1:0] mcr_q;
  logic [EN_W-1:0]   ier_q;
  logic              ri_prev_q;
  logic              rie_q;
  logic              ri_rise;
  logic              msr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= '0;
      ier_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MCR) mcr_q <= wdata[CTRL_W-1:0];
      if (addr == A_IER) ier_q <= wdata[EN_W-1:0];
    end
  end

  assign ri_rise = ri_n_s & ~ri_prev_q;
  assign msr_rd  = rd_en && (addr == A_MSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri_prev_q <= 1'b1;
      rie_q     <= 1'b0;
    end else begin
      ri_prev_q <= ri_n_s;
      if (ri_rise)     rie_q <= 1'b1;
      else if (msr_rd) rie_q <= 1'b0;
    end
  end

  assign irq   = rie_q & ier_q[EB_MS];
  assign dtr_n = ~mcr_q[CB_DTR];
  assign rts_n = ~mcr_q[CB_RTS];
  assign op2_n = ~mcr_q[CB_OP2];

  assign tx_pin = mcr_q[CB_LOOP] ? 1'b1 : tx_in;
  assign rx_out = !rst_n ? 1'b1 : (mcr_q[CB_LOOP] ? tx_in : rx_pin);

  always_comb begin
    rdata = '0;
    case (addr)
      A_IER: rdata[EN_W-1:0]   = ier_q;
      A_ISR: rdata[0]          = ~irq;
      A_MCR: rdata[CTRL_W-1:0] = mcr_q;
      A_MSR: begin
        rdata[SB_RIE] = rie_q;
        rdata[SB_DSR] = ~dsr_n_s;
        rdata[SB_RI]  = ~ri_n_s;
      end
      default: rdata = '0;
    endcase
  end

  AST_DTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCR) |=> (dtr_n == !$past(wdata[CB_DTR]))); // R2
  AST_RTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCR) |=> (rts_n == !$past(wdata[CB_RTS]))); // R3
  AST_OP2_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCR) |=> (op2_n == !$past(wdata[CB_OP2]))); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IER && !wdata[EB_MS]) |=> !irq); // R8
  AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ri_rise) |=> !rie_q); // R7
endmodule

// File: rtl/mdm_ctl_dual.sv
module mdm_ctl_dual
  import mdm_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [NUM_CH-1:0] dsr_n,
  input  logic [NUM_CH-1:0] ri_n,
  output logic [NUM_CH-1:0] dtr_n,
  output logic [NUM_CH-1:0] rts_n,
  output logic [NUM_CH-1:0] op2_n,
  input  logic [NUM_CH-1:0] tx_in,
  output logic [NUM_CH-1:0] tx_pin,
  input  logic [NUM_CH-1:0] rx_pin,
  output logic [NUM_CH-1:0] rx_out,
  output logic              irq_pull_low
);
  localparam int SYNC_W = 2 * NUM_CH;

  logic [SYNC_W-1:0] sync_q;
  logic [NUM_CH-1:0] ri_s, dsr_s;
  logic [NUM_CH-1:0] ch_irq;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  logic              bus_wr, bus_rd;

  mdm_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dsr_n, ri_n}),
    .q     (sync_q)
  );

  assign ri_s  = sync_q[NUM_CH-1:0];
  assign dsr_s = sync_q[SYNC_W-1:NUM_CH];

  assign bus_wr  = !cs_n && !rw;
  assign bus_rd  = !cs_n &&  rw;
  assign data_oe = bus_rd;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = (chan_sel == CH_W'(c));
      mdm_chan u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && sel),
        .rd_en   (bus_rd && sel),
        .addr    (addr),
        .wdata   (data_in),
        .rdata   (ch_rdata[c]),
        .ri_n_s  (ri_s[c]),
        .dsr_n_s (dsr_s[c]),
        .tx_in   (tx_in[c]),
        .tx_pin  (tx_pin[c]),
        .rx_pin  (rx_pin[c]),
        .rx_out  (rx_out[c]),
        .dtr_n   (dtr_n[c]),
        .rts_n   (rts_n[c]),
        .op2_n   (op2_n[c]),
        .irq     (ch_irq[c])
      );
    end
  endgenerate

  always_comb begin
    data_out = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_rd && chan_sel == CH_W'(c)) data_out = ch_rdata[c];
  end

  assign irq_pull_low = |ch_irq;
endmodule

// File: tb/mdm_ctl_dual_tb.sv
module mdm_ctl_dual_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cs_n = 1, rw = 1;
  logic [0:0] chan_sel = 0;
  logic [2:0] addr = 0;
  logic [7:0] data_in = 0;
  logic [7:0] data_out;
  logic       data_oe;
  logic [1:0] dsr_n = 2'b11, ri_n = 2'b11;
  logic [1:0] dtr_n, rts_n, op2_n, tx_pin, rx_out;
  logic [1:0] tx_in = 2'b11, rx_pin = 2'b00;
  logic       irq_pull_low;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  mdm_ctl_dual u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .chan_sel(chan_sel),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dsr_n(dsr_n), .ri_n(ri_n), .dtr_n(dtr_n), .rts_n(rts_n), .op2_n(op2_n),
    .tx_in(tx_in), .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_out(rx_out),
    .irq_pull_low(irq_pull_low)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; rw = 0; chan_sel = ch[0]; addr = a; data_in = d;
    @(negedge clk);
    cs_n = 1; rw = 1;
  endtask

  task automatic rd(input int ch, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; rw = 1; chan_sel = ch[0]; addr = a;
    #1;
    d = data_out;
    chk("R1 oe during read", {31'b0, data_oe}, 1);
    @(negedge clk);
    cs_n = 1;
    #1;
    chk("R1 oe released", {31'b0, data_oe}, 0);
    chk("R1 bus zero released", {24'b0, data_out}, 0);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    #1;
    chk("R11 rx idle in reset", {30'b0, rx_out}, 2'b11);
    chk("R5 dtr reset", {30'b0, dtr_n}, 2'b11);
    chk("R5 rts reset", {30'b0, rts_n}, 2'b11);
    chk("R5 op2 reset", {30'b0, op2_n}, 2'b11);
    chk("R5 irq reset", {31'b0, irq_pull_low}, 0);
    @(negedge clk); rst_n = 1;
    wait_cyc(4);
    for (int ch = 0; ch < 2; ch++)
      for (int a = 0; a < 8; a++) begin
        rd(ch, a[2:0], rv);
        chk("R5 regs zero after reset", {24'b0, rv}, (a == 2) ? 1 : 0);
      end

    // Control register sweep: R2 R3 R4 R10 R12 R14
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        wr(ch, 3'd4, v[7:0]);
        #1;
        chk("R2 dtr", {31'b0, dtr_n[ch]}, {31'b0, ~v[0]});
        chk("R3 rts", {31'b0, rts_n[ch]}, {31'b0, ~v[1]});
        chk("R4 op2", {31'b0, op2_n[ch]}, {31'b0, ~v[3]});
        chk("R12 other dtr", {31'b0, dtr_n[1-ch]}, 1);
        chk("R12 other op2", {31'b0, op2_n[1-ch]}, 1);
        rd(ch, 3'd4, rv);
        chk("R1 ctrl readback", {24'b0, rv}, {27'b0, v[4:0]});
        for (int p = 0; p < 4; p++) begin
          tx_in[ch] = p[0]; rx_pin[ch] = p[1];
          dsr_n = p[1] ? 2'b00 : 2'b11;
          #1;
          chk("R10 rx path", {31'b0, rx_out[ch]}, {31'b0, v[4] ? p[0] : p[1]});
          chk("R10 tx path", {31'b0, tx_pin[ch]}, {31'b0, v[4] ? 1'b1 : p[0]});
          chk("R14 dsr no effect on dtr", {31'b0, dtr_n[ch]}, {31'b0, ~v[0]});
        end
        dsr_n = 2'b11;
      end
      wr(ch, 3'd4, 8'h00);
    end
    wait_cyc(4);

    // Enable register readback R1
    for (int v = 0; v < 16; v++) begin
      wr(1, 3'd1, {4'hA, v[3:0]});
      rd(1, 3'd1, rv);
      chk("R1 enable readback", {24'b0, rv}, {28'b0, v[3:0]});
    end
    wr(1, 3'd1, 8'h00);

    // Status levels R6
    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 4; p++) begin
        dsr_n[ch] = p[0]; ri_n[ch] = 1'b1;
        if (p[1]) ri_n[ch] = 1'b0;
        wait_cyc(4);
        rd(ch, 3'd6, rv);
        chk("R6 status levels", {24'b0, rv & 8'hFB}, {24'b0, {1'b0, p[1], ~p[0], 5'b0}});
        ri_n[ch] = 1'b1; dsr_n[ch] = 1'b1;
        wait_cyc(4);
        rd(ch, 3'd6, rv);
      end

    // Ring edge, interrupt gating, source register: R7 R8 R9 R12
    wr(0, 3'd1, 8'h08);
    ri_n[0] = 0; wait_cyc(5);
    chk("R7 no flag on falling", {31'b0, irq_pull_low}, 0);
    ri_n[0] = 1; wait_cyc(5);
    chk("R8 irq raised", {31'b0, irq_pull_low}, 1);
    rd(0, 3'd2, rv);
    chk("R9 pending source", {24'b0, rv}, 0);
    rd(1, 3'd6, rv);
    chk("R12 other flag clear", {31'b0, rv[2]}, 0);
    wr(0, 3'd6, 8'h00);
    #1;
    chk("R13 status write ignored", {31'b0, irq_pull_low}, 1);
    rd(0, 3'd6, rv);
    chk("R7 flag read", {31'b0, rv[2]}, 1);
    chk("R8 irq after clear", {31'b0, irq_pull_low}, 0);
    rd(0, 3'd6, rv);
    chk("R7 flag cleared", {31'b0, rv[2]}, 0);
    rd(0, 3'd2, rv);
    chk("R9 no pending", {24'b0, rv}, 1);
    wr(0, 3'd1, 8'h00);
    ri_n[0] = 0; wait_cyc(5); ri_n[0] = 1; wait_cyc(5);
    chk("R8 masked", {31'b0, irq_pull_low}, 0);
    wr(0, 3'd1, 8'h08);
    #1;
    chk("R8 enable exposes flag", {31'b0, irq_pull_low}, 1);
    wr(1, 3'd1, 8'h08);
    ri_n[1] = 0; wait_cyc(5); ri_n[1] = 1; wait_cyc(5);
    rd(0, 3'd6, rv);
    chk("R8 or of channels", {31'b0, irq_pull_low}, 1);
    rd(1, 3'd6, rv);
    chk("R8 all cleared", {31'b0, irq_pull_low}, 0);

    // Unused addresses R13
    for (int a = 0; a < 8; a++)
      if (a == 0 || a == 3 || a == 5 || a == 7) begin
        wr(0, a[2:0], 8'hFF);
        rd(0, a[2:0], rv);
        chk("R13 unused reads zero", {24'b0, rv}, 0);
        rd(0, 3'd4, rv);
        chk("R13 ctrl untouched", {24'b0, rv}, 0);
      end

    // Reset with loopback set R5 R11
    wr(0, 3'd4, 8'h1B);
    rx_pin = 2'b00;
    @(negedge clk); rst_n = 0; #1;
    chk("R11 rx idle in reset", {30'b0, rx_out}, 2'b11);
    chk("R5 dtr cleared by reset", {31'b0, dtr_n[0]}, 1);
    @(negedge clk); rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule